// File: doc/BRIEF.md
# Secure Boot Access Policy Controller

This block makes the access decisions a device needs right after reset. It looks at the stored security parameters, which other logic has already checked: whether the user flash is blank, whether the stored key hash is all ones, whether that hash's CRC is good, whether the user-code CRC check is enabled and whether it passes, and the in-circuit write-protect word. It also samples the boot-select pin. From these it sets the debug-port enable, the flash access rights, the choice between running user code and entering the serial downloader, and a decision-done flag. After the decision it reacts to two later events. A completed mass erase reopens the flash. A key-authentication result from the loader decides whether the downloaded loader may run, and with which rights.

Every output is registered. Until the decision is made, every output holds its most restrictive value. The boot-select pin is asynchronous. It passes through a synchronizer and is captured once per reset, so later changes on the pin have no effect until the next reset. The evaluation starts when the parameter inputs are marked valid and the synchronizer has settled.

Top module: `boot_policy_ctrl`

## Requirements
- R1: While `done_o` is low, every policy output (`debug_en_o`, `flash_open_o`, `mass_erase_ok_o`, `dl_mode_o`, `user_run_o`, `ldr_run_o`, `ldr_full_o`, `ldr_deny_o`) is 0.
- R2: With `flash_blank_i`=1 the decision gives debug on, flash open, downloader mode and no user run, whatever the pin and the other parameters are.
- R3: On a non-blank device, read protection is off when `hash_ones_i`=1 and `hash_crc_ok_i`=1. Debug is then enabled (subject to R8).
- R4: On a non-blank device, flash is open when the user CRC passes or its check is disabled (`code_crc_en_i`=0). When the check is enabled and fails, flash is locked and only mass erase is allowed.
- R5: An enabled, failing user CRC forces `user_run_o`=0.
- R6: With read protection on (hash not all ones, or hash CRC invalid), debug is off unless the user CRC check is enabled and failing. In that recovery case debug is on and flash stays locked.
- R7: On a non-blank device, a sampled low pin gives `dl_mode_o`=1 and `user_run_o`=0. A high pin gives `dl_mode_o`=0, and `user_run_o`=1 unless R5 applies.
- R8: A write-protect word equal to 32'h4E6F5772 forces `debug_en_o`=0 on a non-blank device, the recovery case included.
- R9: A `mass_erase_done_i` pulse after the decision sets `flash_open_o`=1 on the next cycle, and this takes priority over an authentication result in the same cycle.
- R10: In downloader mode the first `auth_valid_i` result is applied as follows. A pass gives `ldr_run_o`=1, `ldr_full_o`=1 and flash open. A fail without write protect gives `ldr_run_o`=1, `ldr_full_o`=0 and flash locked. A fail with write protect gives `ldr_deny_o`=1 and `ldr_run_o`=0.
- R11: The boot pin passes through two synchronizer flops and is captured once, when the decision state is entered. Pin changes after that do not alter any output.
- R12: Once set, `done_o` stays high until reset, and `mass_erase_ok_o` is 1 whenever `done_o` is 1.
- R13: An `auth_valid_i` outside downloader mode, or after the first result, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| params_valid_i | input | 1 | Security parameter inputs are valid |
| flash_blank_i | input | 1 | User flash is fully unprogrammed |
| hash_ones_i | input | 1 | Stored key hash is all ones |
| hash_crc_ok_i | input | 1 | Key-hash CRC is valid |
| code_crc_en_i | input | 1 | User-code CRC check is enabled |
| code_crc_ok_i | input | 1 | User-code CRC matches |
| wp_word_i | input | 32 | In-circuit write-protect word |
| boot_pin_i | input | 1 | Asynchronous boot-select pin (low = downloader) |
| mass_erase_done_i | input | 1 | Pulse: mass erase completed |
| auth_valid_i | input | 1 | Pulse: key-authentication result present |
| auth_pass_i | input | 1 | Key-authentication result (1 = match) |
| debug_en_o | output | 1 | Debug port enabled |
| flash_open_o | output | 1 | Flash read, write and page erase allowed |
| mass_erase_ok_o | output | 1 | Mass erase allowed |
| dl_mode_o | output | 1 | Serial downloader mode entered |
| user_run_o | output | 1 | User code may be executed |
| ldr_run_o | output | 1 | Downloaded loader may run |
| ldr_full_o | output | 1 | Loader runs with full permissions |
| ldr_deny_o | output | 1 | Loader refused |
| done_o | output | 1 | Decision complete |

## Verification
The bound checker checks these properties on every cycle:
- all outputs stay quiet before the decision;
- `done_o` and `mass_erase_ok_o` are sticky;
- user run and downloader mode never overlap;
- a refused loader never runs;
- the loader outputs appear only in downloader mode;
- a mass erase reopens the flash;
- debug never changes after the decision.

At the cycle of the decision, the checker also checks the blank-device, failing-CRC and write-protect outcomes against the inputs of the cycle before. The full decision table can only be shown by the bench's scenarios, because each case needs its own reset. The same holds for the three authentication outcomes and the ignoring of late pin changes and repeated or misplaced authentication results.

// File: rtl/boot_policy_pkg.sv
// Shared types for the boot access policy controller.
// Assumes: the default write-protect word spells "NoWr" in ASCII, most significant byte first.
package boot_policy_pkg;
    localparam logic [31:0] NOWR_WORD = 32'h4E6F5772;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_ACTIVE = 2'd2
    } bp_state_e;

    typedef struct packed {
        logic debug_en;
        logic flash_open;
        logic user_run;
        logic dl_mode;
    } bp_policy_t;

    typedef struct packed {
        logic run;
        logic full;
        logic deny;
        logic flash_open;
    } bp_grant_t;
endpackage

// File: rtl/boot_pin_sync.sv
// Multi-flop synchronizer for the asynchronous boot-select pin.
// Assumes: STAGES >= 2. The chain resets to 1 (run user code) until the pin propagates.
module boot_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    logic [STAGES-1:0] chain_q;

    // shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/policy_eval.sv
// Combinational evaluation of the reset-time access policy.
// Assumes: the inputs are stable while the controller is in its decision state.
module policy_eval
    import boot_policy_pkg::*;
#(
    parameter int          WORD_W  = 32,
    parameter logic [WORD_W-1:0] LOCK_WORD = WORD_W'(NOWR_WORD)
) (
    input  logic              blank_i,
    input  logic              hash_ones_i,
    input  logic              hash_crc_ok_i,
    input  logic              crc_en_i,
    input  logic              crc_ok_i,
    input  logic [WORD_W-1:0] wp_word_i,
    input  logic              pin_high_i,
    output bp_policy_t        pol_o,
    output logic              wp_lock_o
);
    logic crc_bad;
    logic prot_on;

    // derive the individual conditions
    always_comb begin
        crc_bad   = crc_en_i & ~crc_ok_i;
        prot_on   = ~(hash_ones_i & hash_crc_ok_i);
        wp_lock_o = (wp_word_i == LOCK_WORD);
    end

    // select the policy: a blank device overrides every check
    always_comb begin
        if (blank_i) begin
            pol_o.debug_en   = 1'b1;
            pol_o.flash_open = 1'b1;
            pol_o.user_run   = 1'b0;
            pol_o.dl_mode    = 1'b1;
        end else begin
            pol_o.debug_en   = (~prot_on | crc_bad) & ~wp_lock_o;
            pol_o.flash_open = ~crc_bad;
            pol_o.user_run   = ~crc_bad & pin_high_i;
            pol_o.dl_mode    = ~pin_high_i;
        end
    end
endmodule

// File: rtl/loader_gate.sv
// Maps a key-authentication result to the rights of the downloaded loader.
// Assumes: only used while the controller is in downloader mode.
module loader_gate
    import boot_policy_pkg::*;
(
    input  logic      pass_i,
    input  logic      wp_lock_i,
    output bp_grant_t grant_o
);
    // pass gives full rights; a fail is softened only without write protect
    always_comb begin
        grant_o.run        = pass_i | ~wp_lock_i;
        grant_o.full       = pass_i;
        grant_o.deny       = ~pass_i & wp_lock_i;
        grant_o.flash_open = pass_i;
    end
endmodule

// File: rtl/boot_policy_ctrl.sv
// Reset-time secure boot access policy controller (top).
// Waits for the pin synchronizer to settle and for valid parameters. It then
// captures the pin once, registers the policy and raises done. After that it
// applies mass-erase and loader-authentication events.
// Assumes: synchronous active-low reset; parameter inputs are held stable while params_valid_i is high.
module boot_policy_ctrl
    import boot_policy_pkg::*;
#(
    parameter int                WORD_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] LOCK_WORD   = WORD_W'(NOWR_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              params_valid_i,
    input  logic              flash_blank_i,
    input  logic              hash_ones_i,
    input  logic              hash_crc_ok_i,
    input  logic              code_crc_en_i,
    input  logic              code_crc_ok_i,
    input  logic [WORD_W-1:0] wp_word_i,
    input  logic              boot_pin_i,
    input  logic              mass_erase_done_i,
    input  logic              auth_valid_i,
    input  logic              auth_pass_i,
    output logic              debug_en_o,
    output logic              flash_open_o,
    output logic              mass_erase_ok_o,
    output logic              dl_mode_o,
    output logic              user_run_o,
    output logic              ldr_run_o,
    output logic              ldr_full_o,
    output logic              ldr_deny_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    bp_state_e  state_q;
    logic [CNT_W-1:0] settle_q;
    logic       pin_sync;
    logic       pin_cap_q;
    bp_policy_t pol_d;
    bp_policy_t pol_q;
    logic       wp_lock_d;
    logic       wp_lock_q;
    bp_grant_t  grant_d;
    logic       flash_q;
    logic       run_q, full_q, deny_q;
    logic       auth_seen_q;
    logic       done_q;

    boot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (boot_pin_i),
        .pin_o (pin_sync)
    );

    policy_eval #(.WORD_W(WORD_W), .LOCK_WORD(LOCK_WORD)) u_eval (
        .blank_i       (flash_blank_i),
        .hash_ones_i   (hash_ones_i),
        .hash_crc_ok_i (hash_crc_ok_i),
        .crc_en_i      (code_crc_en_i),
        .crc_ok_i      (code_crc_ok_i),
        .wp_word_i     (wp_word_i),
        .pin_high_i    (pin_cap_q),
        .pol_o         (pol_d),
        .wp_lock_o     (wp_lock_d)
    );

    loader_gate u_gate (
        .pass_i    (auth_pass_i),
        .wp_lock_i (wp_lock_q),
        .grant_o   (grant_d)
    );

    // sequencing: settle, capture the pin, decide, then stay active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            settle_q  <= '0;
            pin_cap_q <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (settle_q != CNT_W'(SYNC_STAGES)) begin
                        settle_q <= settle_q + 1'b1;
                    end else if (params_valid_i) begin
                        pin_cap_q <= pin_sync;
                        state_q   <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    done_q  <= 1'b1;
                    state_q <= ST_ACTIVE;
                end
                default: state_q <= ST_ACTIVE;
            endcase
        end
    end

    // policy registers: load at decision, then apply later events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q       <= '0;
            wp_lock_q   <= 1'b0;
            flash_q     <= 1'b0;
            run_q       <= 1'b0;
            full_q      <= 1'b0;
            deny_q      <= 1'b0;
            auth_seen_q <= 1'b0;
        end else if (state_q == ST_DECIDE) begin
            pol_q     <= pol_d;
            wp_lock_q <= wp_lock_d;
            flash_q   <= pol_d.flash_open;
        end else if (state_q == ST_ACTIVE) begin
            if (auth_valid_i && pol_q.dl_mode && !auth_seen_q) begin
                run_q       <= grant_d.run;
                full_q      <= grant_d.full;
                deny_q      <= grant_d.deny;
                flash_q     <= grant_d.flash_open;
                auth_seen_q <= 1'b1;
            end
            if (mass_erase_done_i) flash_q <= 1'b1;
        end
    end

    assign debug_en_o      = pol_q.debug_en;
    assign flash_open_o    = flash_q;
    assign mass_erase_ok_o = done_q;
    assign dl_mode_o       = pol_q.dl_mode;
    assign user_run_o      = pol_q.user_run;
    assign ldr_run_o       = run_q;
    assign ldr_full_o      = full_q;
    assign ldr_deny_o      = deny_q;
    assign done_o          = done_q;
endmodule

// File: rtl/boot_policy_chk.sv
// Assertion checker for the boot access policy controller, bound to the top.
// Assumes: synchronous active-low reset; checks are disabled while in reset.
module boot_policy_chk
    import boot_policy_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        flash_blank_i,
    input logic        code_crc_en_i,
    input logic        code_crc_ok_i,
    input logic [31:0] wp_word_i,
    input logic        mass_erase_done_i,
    input logic        debug_en_o,
    input logic        flash_open_o,
    input logic        mass_erase_ok_o,
    input logic        dl_mode_o,
    input logic        user_run_o,
    input logic        ldr_run_o,
    input logic        ldr_full_o,
    input logic        ldr_deny_o,
    input logic        done_o
);
    logic any_out;
    assign any_out = debug_en_o | flash_open_o | mass_erase_ok_o | dl_mode_o |
                     user_run_o | ldr_run_o | ldr_full_o | ldr_deny_o;

    assert_quiet_before_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !any_out);

    assert_blank_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && $past(flash_blank_i)) |-> (debug_en_o && dl_mode_o && !user_run_o));

    assert_crc_fail_no_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && !$past(flash_blank_i) && $past(code_crc_en_i) && !$past(code_crc_ok_i))
        |-> (!user_run_o && !flash_open_o));

    assert_run_dl_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_run_o && dl_mode_o));

    assert_nowr_locks_debug_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && !$past(flash_blank_i) && ($past(wp_word_i) == NOWR_WORD)) |-> !debug_en_o);

    assert_erase_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mass_erase_done_i) |=> flash_open_o);

    assert_loader_rules_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ldr_run_o || ldr_deny_o || ldr_full_o) |-> (dl_mode_o && !(ldr_run_o && ldr_deny_o)
                                                    && (!ldr_full_o || ldr_run_o)));

    assert_debug_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(debug_en_o));

    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && mass_erase_ok_o));
endmodule

bind boot_policy_ctrl boot_policy_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .flash_blank_i     (flash_blank_i),
    .code_crc_en_i     (code_crc_en_i),
    .code_crc_ok_i     (code_crc_ok_i),
    .wp_word_i         (wp_word_i),
    .mass_erase_done_i (mass_erase_done_i),
    .debug_en_o        (debug_en_o),
    .flash_open_o      (flash_open_o),
    .mass_erase_ok_o   (mass_erase_ok_o),
    .dl_mode_o         (dl_mode_o),
    .user_run_o        (user_run_o),
    .ldr_run_o         (ldr_run_o),
    .ldr_full_o        (ldr_full_o),
    .ldr_deny_o        (ldr_deny_o),
    .done_o            (done_o)
);

// File: tb/boot_policy_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected output vectors, a monitor pops and compares them.
// Vector order: {debug, flash, mass_ok, dl, user_run, ldr_run, ldr_full, ldr_deny, done}.
module boot_policy_ctrl_tb_top;
    localparam logic [31:0] NOWR = 32'h4E6F5772;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic params_valid_i = 1'b0;
    logic flash_blank_i = 1'b0, hash_ones_i = 1'b0, hash_crc_ok_i = 1'b0;
    logic code_crc_en_i = 1'b0, code_crc_ok_i = 1'b0;
    logic [31:0] wp_word_i = '1;
    logic boot_pin_i = 1'b1;
    logic mass_erase_done_i = 1'b0, auth_valid_i = 1'b0, auth_pass_i = 1'b0;
    logic debug_en_o, flash_open_o, mass_erase_ok_o, dl_mode_o, user_run_o;
    logic ldr_run_o, ldr_full_o, ldr_deny_o, done_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    event obs_ev;

    always #10 clk = ~clk;

    boot_policy_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .params_valid_i(params_valid_i),
        .flash_blank_i(flash_blank_i), .hash_ones_i(hash_ones_i), .hash_crc_ok_i(hash_crc_ok_i),
        .code_crc_en_i(code_crc_en_i), .code_crc_ok_i(code_crc_ok_i), .wp_word_i(wp_word_i),
        .boot_pin_i(boot_pin_i), .mass_erase_done_i(mass_erase_done_i),
        .auth_valid_i(auth_valid_i), .auth_pass_i(auth_pass_i),
        .debug_en_o(debug_en_o), .flash_open_o(flash_open_o), .mass_erase_ok_o(mass_erase_ok_o),
        .dl_mode_o(dl_mode_o), .user_run_o(user_run_o), .ldr_run_o(ldr_run_o),
        .ldr_full_o(ldr_full_o), .ldr_deny_o(ldr_deny_o), .done_o(done_o)
    );

    // monitor: compare the observed outputs with the next expected item
    initial begin
        forever begin
            @(obs_ev);
            if (sb_q.size() != 0) begin
                sb_item_t it;
                logic [8:0] act;
                it  = sb_q.pop_front();
                act = {debug_en_o, flash_open_o, mass_erase_ok_o, dl_mode_o, user_run_o,
                       ldr_run_o, ldr_full_o, ldr_deny_o, done_o};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    // model of the decision, written from the requirements
    function automatic logic [8:0] model(input logic blank, input logic hones, input logic hcrc,
                                         input logic cen, input logic cok, input logic [31:0] wp,
                                         input logic pin);
        logic bad, prot, lock, dbg, fl, dl, ur;
        bad  = cen && !cok;
        prot = !(hones && hcrc);
        lock = (wp == NOWR);
        if (blank) begin
            dbg = 1; fl = 1; dl = 1; ur = 0;
        end else begin
            dbg = (!prot || bad) && !lock;
            fl  = !bad;
            dl  = !pin;
            ur  = pin && !bad;
        end
        return {dbg, fl, 1'b1, dl, ur, 3'b000, 1'b1};
    endfunction

    // queue an expectation and have the monitor sample it now (at a falling edge)
    task automatic expect_now(input logic [8:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        ->obs_ev;
        #1;
    endtask

    // reset the design with a parameter set, then run the decision
    task automatic start_case(input logic blank, input logic hones, input logic hcrc,
                              input logic cen, input logic cok, input logic [31:0] wp,
                              input logic pin);
        bit seen;
        @(negedge clk);
        rst_n = 0; params_valid_i = 0;
        flash_blank_i = blank; hash_ones_i = hones; hash_crc_ok_i = hcrc;
        code_crc_en_i = cen; code_crc_ok_i = cok; wp_word_i = wp; boot_pin_i = pin;
        repeat (3) @(negedge clk);
        rst_n = 1;
        params_valid_i = 1;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = done_o;
        end
        if (!seen) begin
            checks++; errors++;
            $display("FAIL R12 done never rose actual=0 expected=1");
        end
    endtask

    task automatic pulse_erase();
        mass_erase_done_i = 1;
        @(negedge clk);
        mass_erase_done_i = 0;
    endtask

    task automatic pulse_auth(input logic pass);
        auth_valid_i = 1; auth_pass_i = pass;
        @(negedge clk);
        auth_valid_i = 0; auth_pass_i = 0;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [8:0] e;

    // driver: scenarios
    initial begin
        // R1: quiet before the decision while params are not valid
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; params_valid_i = 0;
        repeat (6) @(negedge clk);
        expect_now(9'b0, "R1 outputs before decision");

        // R2: blank device, pin high, protection parameters all bad
        start_case(1, 0, 0, 1, 0, NOWR, 1);
        expect_now(9'b111100001, "R2 blank device");

        // R3 R4 R7: protection off, CRC passes, pin high
        e = model(0, 1, 1, 1, 1, 32'hFFFF_FFFF, 1);
        start_case(0, 1, 1, 1, 1, 32'hFFFF_FFFF, 1);
        expect_now(e, "R3 R7 protection off crc ok");

        // R4: CRC check disabled keeps flash open
        e = model(0, 1, 1, 0, 0, 32'hFFFF_FFFF, 1);
        start_case(0, 1, 1, 0, 0, 32'hFFFF_FFFF, 1);
        expect_now(e, "R4 crc disabled");

        // R4 R5: CRC fails, then mass erase reopens flash (R9), then pin toggles (R11)
        e = model(0, 1, 1, 1, 0, 32'hFFFF_FFFF, 1);
        start_case(0, 1, 1, 1, 0, 32'hFFFF_FFFF, 1);
        expect_now(e, "R4 R5 crc fail locks");
        pulse_erase();
        e[7] = 1'b1;
        expect_now(e, "R9 mass erase reopens flash");
        boot_pin_i = 0;
        repeat (5) @(negedge clk);
        expect_now(e, "R11 late pin change ignored");

        // R6: protection on, CRC good -> debug off
        e = model(0, 0, 1, 1, 1, 32'h0, 1);
        start_case(0, 0, 1, 1, 1, 32'h0, 1);
        expect_now(e, "R6 protection on debug off");

        // R6: protection on via bad hash CRC, CRC failing -> recovery
        e = model(0, 1, 0, 1, 0, 32'h0, 1);
        start_case(0, 1, 0, 1, 0, 32'h0, 1);
        expect_now(e, "R6 recovery debug on flash locked");

        // R8: write protect word locks debug even with protection off
        e = model(0, 1, 1, 1, 1, NOWR, 1);
        start_case(0, 1, 1, 1, 1, NOWR, 1);
        expect_now(e, "R8 write protect locks debug");

        // R8: write protect beats the recovery path
        e = model(0, 0, 1, 1, 0, NOWR, 1);
        start_case(0, 0, 1, 1, 0, NOWR, 1);
        expect_now(e, "R8 write protect in recovery");

        // R13: authentication outside downloader mode is ignored
        pulse_auth(1);
        expect_now(e, "R13 auth ignored outside downloader");

        // R7 R10: pin low, auth pass, then a later fail is ignored (R13)
        e = model(0, 0, 1, 1, 1, 32'h0, 0);
        start_case(0, 0, 1, 1, 1, 32'h0, 0);
        expect_now(e, "R7 pin low enters downloader");
        pulse_auth(1);
        e[7] = 1'b1; e[3:1] = 3'b110;
        expect_now(e, "R10 auth pass full rights");
        pulse_auth(0);
        expect_now(e, "R13 second auth ignored");

        // R10: auth fail without write protect, then mass erase (R9)
        e = model(0, 0, 1, 1, 1, 32'h0, 0);
        start_case(0, 0, 1, 1, 1, 32'h0, 0);
        pulse_auth(0);
        e[7] = 1'b0; e[3:1] = 3'b100;
        expect_now(e, "R10 auth fail runs with flash locked");
        pulse_erase();
        e[7] = 1'b1;
        expect_now(e, "R9 erase after loader lock");

        // R10: auth fail with write protect refuses loader
        e = model(0, 0, 1, 1, 1, NOWR, 0);
        start_case(0, 0, 1, 1, 1, NOWR, 0);
        pulse_auth(0);
        e[7] = 1'b0; e[3:1] = 3'b001;
        expect_now(e, "R10 auth fail with write protect refused");

        // R9: erase and auth fail in the same cycle -> erase wins
        e = model(0, 0, 1, 1, 1, 32'h0, 0);
        start_case(0, 0, 1, 1, 1, 32'h0, 0);
        mass_erase_done_i = 1; auth_valid_i = 1; auth_pass_i = 0;
        @(negedge clk);
        mass_erase_done_i = 0; auth_valid_i = 0;
        e[7] = 1'b1; e[3:1] = 3'b100;
        expect_now(e, "R9 erase priority over auth");

        // R12: done and mass-erase permission held
        repeat (10) @(negedge clk);
        expect_now(e, "R12 done sticky");

        // R2 R11: blank with pin low still gives downloader, no user run
        start_case(1, 1, 1, 1, 1, 32'h0, 0);
        expect_now(9'b111100001, "R2 blank pin low");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule